// File: doc/BRIEF.md
# Contactless Transmit Line Encoder

This block turns a stream of data bits, handed over one at a time through a valid/ready handshake, into the modulation envelope that drives a 13.56 MHz reader transmitter. All timing is derived from the carrier clock. A 3-bit coding selector picks one of seven line codings: plain level, Manchester, Manchester gated by a subcarrier, BPSK on a subcarrier, two return-to-zero pulse placements, and a double-Manchester "tuple" form. A 3-bit rate selector sets the bit period. A single select bit sets the subcarrier to 424 kHz or 848 kHz.

A transfer starts when a bit is accepted while the encoder is idle. The coding, rate and subcarrier settings are captured at that moment and held until the encoder returns to idle. While busy, the encoder asks for the next bit in the last carrier cycle of each bit period. If no bit is offered then, it falls back to idle and holds the envelope low, which is the unmodulated level.

Top module: `clTxEncoder`

## Requirements
- R1: While reset is asserted and immediately after it, busy is 0, envOut is 0, bitStrobe is 0, and inReady is 1 unless cfgMode is 111.
- R2: The bit period in carrier cycles follows cfgRate: 000→8, 001→4, 010→512, 011→256, 100→128, 101→64, 110→32, 111→16. A bit accepted on a clock edge starts its period in the next cycle. bitStrobe is high in the first cycle of every bit period. While busy, inReady is high only in the last cycle of a bit period.
- R3: Coding 000 drives envOut equal to the current bit for the whole bit period.
- R4: Coding 001 drives the bit value during the first half of the period and its inverse during the second half.
- R5: Coding 010 drives the coding 001 level ANDed with the subcarrier. The subcarrier has a period of 32 cycles when cfgSubSel is 0 and 16 cycles when it is 1. It is high in the first half of its period, with its phase counted from the first cycle of the transfer.
- R6: Coding 011 drives the subcarrier XORed with a phase flag. The flag starts equal to the first bit of a transfer and toggles at the start of each later bit whose value differs from the bit before it.
- R7: Coding 100 drives envOut high only during the second half of periods whose bit is 1.
- R8: Coding 101 drives envOut high only during the first half of periods whose bit is 1.
- R9: Coding 110 splits the period into quarters. It drives the bit value in quarters 0 and 2 and the inverse in quarters 1 and 3.
- R10: Coding 111 is reserved. The encoder never raises inReady, never becomes busy, and keeps envOut low.
- R11: If inValid is low in the last cycle of a bit period, busy falls after that cycle, envOut is 0 while idle, and inReady stays high in idle.
- R12: Changes to cfgMode, cfgRate or cfgSubSel while busy have no effect until the next transfer starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock (13.56 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 3 | Line coding select |
| cfgRate | input | 3 | Bit period select |
| cfgSubSel | input | 1 | Subcarrier select, 0 = carrier/32, 1 = carrier/16 |
| inValid | input | 1 | Data bit offered |
| inBit | input | 1 | Data bit value |
| inReady | output | 1 | Encoder takes the offered bit on this edge |
| envOut | output | 1 | Modulation envelope |
| bitStrobe | output | 1 | First cycle of each bit period |
| busy | output | 1 | Transfer in progress |

## Verification
A wrong period counter or a wrong latched rate shows up within one bit period as a misplaced inReady or bitStrobe pulse. It also appears as an envOut edge in the wrong cycle. A corrupted phase flag or a stale previous-bit value in BPSK inverts the whole subcarrier from the next bit onward. A wrong subcarrier phase misaligns the gated Manchester pattern within one subcarrier period. The reference model is compared on every clock, so any of these faults is reported in the cycle where it first changes a port.

// File: rtl/clTxPkg.sv
package clTxPkg;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_MAN     = 3'd1,
    MODE_MANSC   = 3'd2,
    MODE_BPSK    = 3'd3,
    MODE_RZLATE  = 3'd4,
    MODE_RZEARLY = 3'd5,
    MODE_TUPLE   = 3'd6,
    MODE_RSVD    = 3'd7
  } txMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // a bit is accepted on this edge
    logic fresh;  // that bit opens a new transfer
  } ctrlStb_t;

  // log2 of the bit period in carrier cycles for a rate code
  function automatic logic [3:0] periodLog2(input logic [2:0] code);
    if (code >= 3'd2) return 4'd11 - {1'b0, code};
    else              return 4'd3 - {1'b0, code};
  endfunction

endpackage

// File: rtl/clTxCtrl.sv
module clTxCtrl
  import clTxPkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int SC_SLOW = 5,  // log2 of slow subcarrier period
  parameter int SC_FAST = 4   // log2 of fast subcarrier period
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgMode,
  input  logic [2:0] cfgRate,
  input  logic       cfgSubSel,
  input  logic       inValid,
  output logic       inReady,
  output logic       busy,
  output logic       bitStrobe,
  output ctrlStb_t   stb,
  output txMode_e    modeQ,
  output logic       firstHalf,
  output logic       quarterOdd,
  output logic       scOn
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] phase;
  logic [2:0]       rateQ;
  logic             subQ;
  logic [3:0]       lgQ;
  logic [CNT_W-1:0] mask, pos, shHalf, shQuart;
  logic             posLast;

  assign lgQ     = periodLog2(rateQ);
  assign mask    = (ONE << lgQ) - ONE;
  assign pos     = phase & mask;
  assign posLast = (pos == mask);
  assign shHalf  = phase >> (lgQ - 4'd1);
  assign shQuart = phase >> (lgQ - 4'd2);

  assign firstHalf  = ~shHalf[0];
  assign quarterOdd = shQuart[0];
  assign scOn       = subQ ? ~phase[SC_FAST-1] : ~phase[SC_SLOW-1];

  assign inReady   = busy ? posLast : (cfgMode != MODE_RSVD);
  assign stb.take  = inValid & inReady;
  assign stb.fresh = inValid & inReady & ~busy;
  assign bitStrobe = busy & (pos == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      phase <= '0;
      modeQ <= MODE_DIRECT;
      rateQ <= 3'd0;
      subQ  <= 1'b0;
    end else if (stb.fresh) begin
      busy  <= 1'b1;
      phase <= '0;
      modeQ <= txMode_e'(cfgMode);
      rateQ <= cfgRate;
      subQ  <= cfgSubSel;
    end else if (busy) begin
      if (posLast && !inValid) busy <= 1'b0;
      phase <= phase + ONE;
    end
  end

  // R2: an accepted bit opens a period on the next cycle
  p_strobe_after_take_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> bitStrobe);

  // R2, R11: a boundary either continues or ends the transfer
  p_boundary_exit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && inReady && !inValid) |=> !busy);

  // R10: the reserved coding never takes data
  p_reserved_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgMode == MODE_RSVD) |-> !inReady);

  // R12: captured settings hold for the whole transfer
  p_cfg_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(modeQ) && $stable(rateQ) && $stable(subQ)));

endmodule

// File: rtl/clTxDatapath.sv
module clTxDatapath
  import clTxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  input  logic     inBit,
  input  logic     busy,
  input  txMode_e  modeQ,
  input  logic     firstHalf,
  input  logic     quarterOdd,
  input  logic     scOn,
  output logic     envOut
);

  logic curBit;
  logic flipQ;
  logic manLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBit <= 1'b0;
      flipQ  <= 1'b0;
    end else if (stb.take) begin
      curBit <= inBit;
      flipQ  <= stb.fresh ? inBit : (flipQ ^ (inBit ^ curBit));
    end
  end

  assign manLevel = firstHalf ? curBit : ~curBit;

  always_comb begin
    envOut = 1'b0;
    if (busy) begin
      unique case (modeQ)
        MODE_DIRECT:  envOut = curBit;
        MODE_MAN:     envOut = manLevel;
        MODE_MANSC:   envOut = manLevel & scOn;
        MODE_BPSK:    envOut = scOn ^ flipQ;
        MODE_RZLATE:  envOut = curBit & ~firstHalf;
        MODE_RZEARLY: envOut = curBit & firstHalf;
        MODE_TUPLE:   envOut = quarterOdd ? ~curBit : curBit;
        default:      envOut = 1'b0;
      endcase
    end
  end

  // R11: idle envelope is unmodulated
  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !envOut);

  // R8: early pulse never appears in the second half
  p_rz_early_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && modeQ == MODE_RZEARLY && !firstHalf) |-> !envOut);

endmodule

// File: rtl/clTxEncoder.sv
module clTxEncoder
  import clTxPkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cfgMode,
  input  logic [2:0] cfgRate,
  input  logic       cfgSubSel,
  input  logic       inValid,
  input  logic       inBit,
  output logic       inReady,
  output logic       envOut,
  output logic       bitStrobe,
  output logic       busy
);

  ctrlStb_t stb;
  txMode_e  modeQ;
  logic     firstHalf, quarterOdd, scOn;

  clTxCtrl #(.CNT_W(CNT_W), .SC_SLOW(5), .SC_FAST(4)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgRate(cfgRate),
    .cfgSubSel(cfgSubSel), .inValid(inValid), .inReady(inReady),
    .busy(busy), .bitStrobe(bitStrobe), .stb(stb), .modeQ(modeQ),
    .firstHalf(firstHalf), .quarterOdd(quarterOdd), .scOn(scOn)
  );

  clTxDatapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .inBit(inBit), .busy(busy),
    .modeQ(modeQ), .firstHalf(firstHalf), .quarterOdd(quarterOdd),
    .scOn(scOn), .envOut(envOut)
  );

endmodule

// File: tb/clTxEncoder_test.sv
`timescale 1ns/1ps
module clTxEncoder_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] cfgMode = 3'd0;
  logic [2:0] cfgRate = 3'd0;
  logic       cfgSubSel = 1'b0;
  logic       inValid = 1'b0;
  logic       inBit = 1'b0;
  logic       inReady, envOut, bitStrobe, busy;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  string curTag = "";

  clTxEncoder uut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgRate(cfgRate),
    .cfgSubSel(cfgSubSel), .inValid(inValid), .inBit(inBit),
    .inReady(inReady), .envOut(envOut), .bitStrobe(bitStrobe), .busy(busy)
  );

  always #10 clk = ~clk;

  // reference model state
  bit mBusy = 0;
  int mCnt = 0;
  bit mBit = 0;
  bit mFlip = 0;
  int mMode = 0;
  int mRate = 0;
  bit mSub = 0;
  bit accEdge = 0;

  function automatic int periodOf(input int code);
    case (code)
      0: return 8;   1: return 4;   2: return 512; 3: return 256;
      4: return 128; 5: return 64;  6: return 32;  default: return 16;
    endcase
  endfunction

  function automatic string tagOf(input int mode);
    case (mode)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic bit expReady();
    int p;
    p = periodOf(mRate);
    if (mBusy) return (mCnt % p) == p - 1;
    return cfgMode != 3'd7;
  endfunction

  function automatic bit expEnv();
    int p, pos, s;
    bit first, sc, man;
    if (!mBusy) return 1'b0;
    p     = periodOf(mRate);
    pos   = mCnt % p;
    first = pos < p / 2;
    s     = mSub ? 16 : 32;
    sc    = (mCnt % s) < s / 2;
    man   = first ? mBit : !mBit;
    case (mMode)
      0: return mBit;
      1: return man;
      2: return man & sc;
      3: return sc ^ mFlip;
      4: return mBit & !first;
      5: return mBit & first;
      6: return ((pos / (p / 4)) % 2 == 0) ? mBit : !mBit;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cycles, act, exp);
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 0; mCnt <= 0; mBit <= 0; mFlip <= 0;
      mMode <= 0; mRate <= 0; mSub <= 0; accEdge <= 0;
    end else begin
      bit acc;
      int p;
      p = periodOf(mRate);
      acc = inValid && expReady();
      accEdge <= acc;
      if (!mBusy) begin
        if (acc) begin
          mBusy <= 1; mCnt <= 0; mBit <= inBit; mFlip <= inBit;
          mMode <= int'(cfgMode); mRate <= int'(cfgRate); mSub <= cfgSubSel;
        end
      end else if ((mCnt % p) == p - 1) begin
        if (acc) begin
          mFlip <= mFlip ^ (inBit != mBit);
          mBit <= inBit;
          mCnt <= mCnt + 1;
        end else mBusy <= 0;
      end else mCnt <= mCnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      string et;
      int p;
      cycles++;
      p = periodOf(mRate);
      et = (curTag != "") ? curTag : (mBusy ? tagOf(mMode) : "R11");
      check("R2", "inReady", inReady, expReady());
      check("R2", "bitStrobe", bitStrobe, mBusy && (mCnt % p) == 0);
      check("R11", "busy", busy, mBusy);
      check(et, "envOut", envOut, expEnv());
    end
  end

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  task automatic sendBits(input int mode, input int rate, input bit sub,
                          input logic [7:0] pat, input int n, input bit chg);
    int idx;
    @(posedge clk); #2;
    cfgMode = 3'(mode); cfgRate = 3'(rate); cfgSubSel = sub;
    inValid = 1; idx = 0; inBit = pat[n-1];
    while (idx < n) begin
      @(posedge clk); #2;
      if (accEdge) begin
        idx++;
        if (idx == n) inValid = 0;
        else inBit = pat[n-1-idx];
        if (chg && idx == 2) begin
          // R12: disturb the settings mid-transfer
          cfgMode = 3'd0; cfgRate = 3'd1; cfgSubSel = ~cfgSubSel;
        end
      end
    end
    while (mBusy) @(posedge clk);
    repeat (3) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1", "busy in reset", busy, 0);
    check("R1", "envOut in reset", envOut, 0);
    check("R1", "inReady in reset", inReady, 1);
    rstN = 1;
    @(posedge clk); #2;
    check("R1", "busy after reset", busy, 0);
    check("R1", "bitStrobe after reset", bitStrobe, 0);

    sendBits(0, 1, 0, 8'b10110010, 8, 0);   // R3
    sendBits(0, 2, 0, 8'b00000010, 2, 0);   // R2 longest period
    sendBits(1, 0, 0, 8'b11010011, 8, 0);   // R4
    sendBits(2, 6, 0, 8'b10110100, 6, 0);   // R5 slow subcarrier
    sendBits(2, 7, 1, 8'b01101101, 8, 0);   // R5 fast subcarrier
    sendBits(3, 6, 1, 8'b11001010, 8, 0);   // R6
    sendBits(3, 0, 0, 8'b10011101, 8, 0);   // R6 short period
    sendBits(4, 4, 0, 8'b10110001, 8, 0);   // R7
    sendBits(5, 5, 1, 8'b01110010, 8, 0);   // R8
    sendBits(6, 1, 0, 8'b10100110, 8, 0);   // R9
    sendBits(6, 3, 0, 8'b00001011, 4, 0);   // R9 long period
    sendBits(1, 7, 0, 8'b00000101, 3, 0);   // R11 short burst then idle
    repeat (5) @(posedge clk);
    #2;
    check("R11", "idle ready", inReady, 1);
    curTag = "R12";
    sendBits(6, 7, 0, 8'b11010110, 8, 1);   // R12
    curTag = "R12";
    sendBits(3, 6, 0, 8'b01100111, 8, 1);   // R12 with BPSK
    curTag = "R10";
    @(posedge clk); #2;
    cfgMode = 3'd7; inValid = 1; inBit = 1;
    repeat (30) @(posedge clk);
    #2;
    check("R10", "busy with reserved coding", busy, 0);
    inValid = 0; cfgMode = 3'd0; curTag = "";
    repeat (4) @(posedge clk);
    finishRun();
  end

endmodule